// File: doc/BRIEF.md
# Byte-Register Serial Port Core

This core is an asynchronous serial port controlled through a small set of byte-wide registers. A host reaches it over a simple bus with an address, a write strobe, a read strobe and an 8-bit data bus. Read data is combinational within the strobe cycle. The registers are spaced at a power-of-two byte stride chosen by a parameter, so the core can sit on 8-, 16- or 32-bit-aligned buses without changes.

Software writes a 16-bit divisor through a latch window that a control bit opens. The divisor sets a tick at sixteen times the bit rate. Bytes written to the data register queue in a transmit FIFO and leave the TX wire as frames with one start bit, eight data bits sent least significant bit first, and one stop bit. Frames arriving on the RX wire are sampled against the same tick and collected in a receive FIFO. The host reads them from the data register. A line-status register and an extended status register let polling software see when it can send, when the line has drained and when input is waiting.

Top module: `uart_regs_core`

## Requirements
- R1: After reset the divisor is 0, and while it is 0 no baud tick occurs, so a queued byte never starts and TX stays high. After reset, line status (index 5) reads 0x60 and extended status (index 0x1f) reads 0x06.
- R2: When line-control (index 3) bit 7 is 1, index 0 reads and writes the low divisor byte and index 1 the high divisor byte. Writes in this mode do not reach the transmit FIFO. When bit 7 is 0, index 1 is the 8-bit interrupt-enable storage. Line control reads back as written.
- R3: The register index is the byte address shifted right by REG_SHIFT. The address bits below REG_SHIFT are ignored.
- R4: Each frame on TX is one low start bit, eight data bits sent LSB first and one high stop bit. Every bit lasts 16 × divisor clock cycles.
- R5: Line-status bit 5 is 1 when the transmit FIFO is empty. Bit 6 is 1 only when the transmit FIFO is empty and the serializer is idle.
- R6: Extended status bit 1 is 1 when the transmit FIFO is not full. Bit 2 is 1 when it is empty. All other bits read 0.
- R7: The transmit FIFO holds 16 bytes. A data write while it is full is dropped, and bytes are sent in write order.
- R8: Line-status bit 0 is 1 while at least one received byte is waiting. A read of index 0 with bit 7 of line control clear returns the oldest byte and removes it.
- R9: A byte that arrives while the 16-entry receive FIFO is full is lost. It sets line-status bit 1, which stays set until line status is read.
- R10: A stop bit sampled low still stores the byte, and it sets line-status bit 3 until line status is read. After a low stop bit, a new start is only taken after the line has been seen high.
- R11: A start is taken only if RX is still low at the 8th tick after a falling edge. A shorter low pulse stores nothing.
- R12: A write to index 2 with bit 1 set empties the receive FIFO. With bit 2 set it empties the transmit FIFO.
- R13: Modem control (index 4) stores and returns its low 5 bits, with the upper bits reading 0. Index 2, index 7 and all other unused indexes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; side effects at the clock edge ending it |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe cycle |
| ser_tx | output | 1 | Serial transmit line, idle high |
| ser_rx | input | 1 | Serial receive line, synchronized internally |

## Verification
The bench checks that a zero divisor truly freezes the transmitter. A design that still ticked would push a frame out with no rate programmed. It overfills the transmit FIFO and loops the line back to show that the seventeenth byte is missing and that the order is kept. A pointer or full-flag slip would corrupt or duplicate bytes. It then sends 17 frames with no reads, a frame with a low stop bit and a short low glitch, and checks that the sticky flags clear only on a status read. These cases catch a receiver that overwrites old data, re-triggers on a held-low line, or accepts noise as a start bit.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_START = 2'd1,
    LN_DATA  = 2'd2,
    LN_STOP  = 2'd3
  } line_st_e;

  localparam int IDX_DATA  = 0;
  localparam int IDX_IEN   = 1;
  localparam int IDX_FCTL  = 2;
  localparam int IDX_LCTL  = 3;
  localparam int IDX_MCTL  = 4;
  localparam int IDX_LSTAT = 5;
  localparam int IDX_XSTAT = 31;

  localparam int DIV_WIN_BIT = 7;
  localparam int FLUSH_RX_BIT = 1;
  localparam int FLUSH_TX_BIT = 2;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = adv(wp_q);
      if (pop_ok)  rp_d = adv(rp_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= din;
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (divisor == '0) begin
      cnt_d = '0;
    end else if (cnt_q >= divisor - DIV_W'(1)) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
  import uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8,
  localparam int CW = $clog2(OSR),
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  output logic          txd,
  output logic          busy
);

  line_st_e      st_q, st_d;
  logic [CW-1:0] tc_q, tc_d;
  logic [BW-1:0] bi_q, bi_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          txd_q, txd_d;

  always_comb begin
    st_d     = st_q;
    tc_d     = tc_q;
    bi_d     = bi_q;
    sh_d     = sh_q;
    fifo_pop = 1'b0;
    if (st_q == LN_IDLE) begin
      if (tick && !fifo_empty) begin
        fifo_pop = 1'b1;
        sh_d     = fifo_data;
        st_d     = LN_START;
        tc_d     = '0;
      end
    end else if (tick) begin
      if (tc_q == CW'(OSR - 1)) begin
        tc_d = '0;
        case (st_q)
          LN_START: begin
            st_d = LN_DATA;
            bi_d = '0;
          end
          LN_DATA: begin
            sh_d = sh_q >> 1;
            if (bi_q == BW'(DW - 1)) st_d = LN_STOP;
            else                     bi_d = bi_q + 1'b1;
          end
          default: st_d = LN_IDLE;
        endcase
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
    case (st_d)
      LN_START: txd_d = 1'b0;
      LN_DATA:  txd_d = sh_d[0];
      default:  txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      tc_q  <= '0;
      bi_q  <= '0;
      sh_q  <= '0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      bi_q  <= bi_d;
      sh_q  <= sh_d;
      txd_q <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign busy = (st_q != LN_IDLE);

endmodule

// File: rtl/uart_rx_serial.sv
module uart_rx_serial
  import uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8,
  localparam int CW = $clog2(OSR),
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  output logic          push,
  output logic          frame_err,
  output logic [DW-1:0] data
);

  line_st_e      st_q, st_d;
  logic [CW-1:0] tc_q, tc_d;
  logic [BW-1:0] bi_q, bi_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          last_q, last_d;

  always_comb begin
    st_d      = st_q;
    tc_d      = tc_q;
    bi_d      = bi_q;
    sh_d      = sh_q;
    push      = 1'b0;
    frame_err = 1'b0;
    last_d    = tick ? rxd : last_q;
    if (tick) begin
      case (st_q)
        LN_IDLE: begin
          if (!rxd && last_q) begin
            st_d = LN_START;
            tc_d = '0;
          end
        end
        LN_START: begin
          if (tc_q == CW'(OSR / 2 - 1)) begin
            tc_d = '0;
            bi_d = '0;
            st_d = rxd ? LN_IDLE : LN_DATA;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        LN_DATA: begin
          if (tc_q == CW'(OSR - 1)) begin
            tc_d = '0;
            sh_d = {rxd, sh_q[DW-1:1]};
            if (bi_q == BW'(DW - 1)) st_d = LN_STOP;
            else                     bi_d = bi_q + 1'b1;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        default: begin
          if (tc_q == CW'(OSR - 1)) begin
            push      = 1'b1;
            frame_err = !rxd;
            st_d      = LN_IDLE;
            tc_d      = '0;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      tc_q   <= '0;
      bi_q   <= '0;
      sh_q   <= '0;
      last_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      tc_q   <= tc_d;
      bi_q   <= bi_d;
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  assign data = sh_q;

endmodule

// File: rtl/uart_regs_core.sv
module uart_regs_core
  import uart_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_SHIFT  = 0,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  localparam int IW        = ADDR_W - REG_SHIFT,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              ser_tx,
  input  logic              ser_rx
);

  logic [IW-1:0]    reg_idx;
  logic [7:0]       lcr_q, lcr_d, ien_q, ien_d;
  logic [4:0]       mcr_q, mcr_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             oe_q, oe_d, fe_q, fe_d;
  logic             rx_s1_q, rx_s2_q;
  logic             div_win;
  logic             hit_data, hit_ien, hit_fctl, hit_lctl, hit_mctl, hit_lstat, hit_xstat;

  logic             baud_tick;
  logic             tx_push, tx_pop, tx_flush, tx_empty, tx_full, tx_busy;
  logic [7:0]       tx_head;
  logic [CW-1:0]    tx_count;
  logic             rx_push, rx_pop, rx_flush, rx_empty, rx_full, rx_ferr;
  logic [7:0]       rx_byte, rx_head;
  logic [CW-1:0]    rx_count;
  logic             lstat_rd;
  logic [7:0]       lstat, xstat;

  assign reg_idx   = bus_addr[ADDR_W-1:REG_SHIFT];
  assign div_win   = lcr_q[DIV_WIN_BIT];
  assign hit_data  = (reg_idx == IW'(IDX_DATA));
  assign hit_ien   = (reg_idx == IW'(IDX_IEN));
  assign hit_fctl  = (reg_idx == IW'(IDX_FCTL));
  assign hit_lctl  = (reg_idx == IW'(IDX_LCTL));
  assign hit_mctl  = (reg_idx == IW'(IDX_MCTL));
  assign hit_lstat = (reg_idx == IW'(IDX_LSTAT));
  assign hit_xstat = (reg_idx == IW'(IDX_XSTAT));

  assign tx_push  = bus_wr && hit_data && !div_win;
  assign tx_flush = bus_wr && hit_fctl && bus_wdata[FLUSH_TX_BIT];
  assign rx_flush = bus_wr && hit_fctl && bus_wdata[FLUSH_RX_BIT];
  assign rx_pop   = bus_rd && hit_data && !div_win;
  assign lstat_rd = bus_rd && hit_lstat;

  always_comb begin
    lcr_d = lcr_q;
    ien_d = ien_q;
    mcr_d = mcr_q;
    div_d = div_q;
    if (bus_wr) begin
      if (hit_lctl) lcr_d = bus_wdata;
      if (hit_mctl) mcr_d = bus_wdata[4:0];
      if (hit_data && div_win) div_d[7:0] = bus_wdata;
      if (hit_ien && div_win)  div_d[DIV_W-1:8] = bus_wdata[DIV_W-9:0];
      if (hit_ien && !div_win) ien_d = bus_wdata;
    end
    oe_d = (oe_q && !lstat_rd) || (rx_push && rx_full);
    fe_d = (fe_q && !lstat_rd) || (rx_push && rx_ferr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q   <= '0;
      ien_q   <= '0;
      mcr_q   <= '0;
      div_q   <= '0;
      oe_q    <= 1'b0;
      fe_q    <= 1'b0;
      rx_s1_q <= 1'b1;
      rx_s2_q <= 1'b1;
    end else begin
      if (bus_wr) begin
        lcr_q <= lcr_d;
        ien_q <= ien_d;
        mcr_q <= mcr_d;
        div_q <= div_d;
      end
      oe_q    <= oe_d;
      fe_q    <= fe_d;
      rx_s1_q <= ser_rx;
      rx_s2_q <= rx_s1_q;
    end
  end

  assign lstat = {1'b0, tx_empty && !tx_busy, tx_empty, 1'b0, fe_q, 1'b0, oe_q, !rx_empty};
  assign xstat = {5'b0, tx_empty, !tx_full, 1'b0};

  always_comb begin
    bus_rdata = '0;
    if (hit_data)       bus_rdata = div_win ? div_q[7:0] : rx_head;
    else if (hit_ien)   bus_rdata = div_win ? 8'(div_q[DIV_W-1:8]) : ien_q;
    else if (hit_lctl)  bus_rdata = lcr_q;
    else if (hit_mctl)  bus_rdata = {3'b0, mcr_q};
    else if (hit_lstat) bus_rdata = lstat;
    else if (hit_xstat) bus_rdata = xstat;
  end

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(div_q), .tick(baud_tick)
  );

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .flush(tx_flush),
    .din(bus_wdata), .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  uart_tx_serial #(.OSR(16), .DW(8)) u_txs (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .fifo_empty(tx_empty),
    .fifo_data(tx_head), .fifo_pop(tx_pop), .txd(ser_tx), .busy(tx_busy)
  );

  uart_rx_serial #(.OSR(16), .DW(8)) u_rxs (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rx_s2_q),
    .push(rx_push), .frame_err(rx_ferr), .data(rx_byte)
  );

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .flush(rx_flush),
    .din(rx_byte), .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

endmodule

// File: rtl/uart_regs_checker.sv
module uart_regs_checker #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    tx_count,
  input logic [CW-1:0]    rx_count,
  input logic             tx_pop,
  input logic             tx_flush,
  input logic [DIV_W-1:0] divisor,
  input logic             baud_tick,
  input logic             tx_busy,
  input logic             ser_tx,
  input logic             rx_push,
  input logic             rx_flush,
  input logic             rx_empty
);

  p_no_tick_div0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !baud_tick);

  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_tx);

  p_tx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH) && !tx_pop && !tx_flush) |=> (tx_count == CW'(DEPTH)));

  p_push_sets_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_flush) |=> !rx_empty);

  p_rx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

endmodule

bind uart_regs_core uart_regs_checker #(.DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
  .tx_pop(tx_pop), .tx_flush(tx_flush), .divisor(div_q), .baud_tick(baud_tick),
  .tx_busy(tx_busy), .ser_tx(ser_tx), .rx_push(rx_push), .rx_flush(rx_flush),
  .rx_empty(rx_empty)
);

// File: tb/sim_uart_regs_core.sv
module sim_uart_regs_core;

  localparam int SHIFT = 2;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          ser_tx;
  logic          rx_drv = 1'b1;
  logic          loop_en = 1'b0;
  logic          ser_rx;
  int            n_chk = 0;
  int            n_fail = 0;
  logic          done = 1'b0;

  assign ser_rx = loop_en ? ser_tx : rx_drv;

  always #2.5 clk = ~clk;

  uart_regs_core #(.ADDR_W(AW), .REG_SHIFT(SHIFT), .FIFO_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_tx(ser_tx), .ser_rx(ser_rx)
  );

  // vector: {op(1=read,0=write), index, write data, expected read, requirement}
  localparam int NV = 24;
  localparam logic [26:0] VEC [NV] = '{
    {2'd1, 5'h05, 8'h00, 8'h60, 4'd1},  // R1 line status after reset
    {2'd1, 5'h1f, 8'h00, 8'h06, 4'd1},  // R1 extended status after reset
    {2'd0, 5'h01, 8'h0f, 8'h00, 4'd2},
    {2'd1, 5'h01, 8'h00, 8'h0f, 4'd2},  // R2 enable storage
    {2'd0, 5'h03, 8'h83, 8'h00, 4'd2},
    {2'd1, 5'h03, 8'h00, 8'h83, 4'd2},  // R2 line control readback
    {2'd0, 5'h00, 8'h34, 8'h00, 4'd2},
    {2'd0, 5'h01, 8'h12, 8'h00, 4'd2},
    {2'd1, 5'h00, 8'h00, 8'h34, 4'd2},  // R2 divisor low
    {2'd1, 5'h01, 8'h00, 8'h12, 4'd2},  // R2 divisor high
    {2'd0, 5'h03, 8'h03, 8'h00, 4'd2},
    {2'd1, 5'h01, 8'h00, 8'h0f, 4'd2},  // R2 window closed
    {2'd1, 5'h03, 8'h00, 8'h03, 4'd2},
    {2'd0, 5'h03, 8'h83, 8'h00, 4'd2},
    {2'd0, 5'h00, 8'h00, 8'h00, 4'd2},
    {2'd0, 5'h01, 8'h00, 8'h00, 4'd2},
    {2'd0, 5'h03, 8'h03, 8'h00, 4'd2},
    {2'd0, 5'h04, 8'h1f, 8'h00, 4'd13},
    {2'd1, 5'h04, 8'h00, 8'h1f, 4'd13}, // R13 modem control storage
    {2'd0, 5'h04, 8'hff, 8'h00, 4'd13},
    {2'd1, 5'h04, 8'h00, 8'h1f, 4'd13}, // R13 only five bits kept
    {2'd1, 5'h07, 8'h00, 8'h00, 4'd13}, // R13 unused index
    {2'd1, 5'h02, 8'h00, 8'h00, 4'd13}, // R13 write-only index
    {2'd1, 5'h05, 8'h00, 8'h60, 4'd2}   // R2 divisor writes queued nothing
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_raw(input logic [AW-1:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    wr_raw(AW'(idx << SHIFT), d);
  endtask

  task automatic rd_chk(input int idx, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd_raw(AW'(idx << SHIFT), v);
    check(v, exp, req);
  endtask

  task automatic set_div(input logic [15:0] dv);
    wr(3, 8'h83);
    wr(0, dv[7:0]);
    wr(1, dv[15:8]);
    wr(3, 8'h03);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int bitlen);
    rx_drv = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = b[i];
      repeat (bitlen) @(negedge clk);
    end
    rx_drv = stop;
    repeat (bitlen) @(negedge clk);
    rx_drv = 1'b1;
  endtask

  task automatic capture(input int bitlen, output logic [7:0] b, output logic stopb);
    @(negedge ser_tx);
    repeat (bitlen / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bitlen) @(negedge clk);
      b[i] = ser_tx;
    end
    repeat (bitlen) @(negedge clk);
    stopb = ser_tx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] cap;
    logic       stp;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({7'b0, ser_tx}, 8'h01, "R1 idle line");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][26:25] == 2'd0) begin
        wr(int'(VEC[k][24:20]), VEC[k][19:12]);
      end else begin
        rd_raw(AW'(int'(VEC[k][24:20]) << SHIFT), v);
        n_chk++;
        if (v !== VEC[k][11:4]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d: actual %02h expected %02h", VEC[k][3:0], k, v, VEC[k][11:4]);
        end
      end
    end

    // R3: low address bits below the stride are ignored
    rd_raw(AW'((31 << SHIFT) | 1), v);
    check(v, 8'h06, "R3 offset alias");

    // R1: zero divisor freezes the transmitter
    wr(0, 8'h55);
    repeat (100) @(negedge clk);
    check({7'b0, ser_tx}, 8'h01, "R1 no frame at divisor 0");
    rd_chk(5, 8'h00, "R5 queued byte clears both flags");
    wr(2, 8'h04);
    rd_chk(5, 8'h60, "R12 transmit flush");

    // R6 / R7: fill the transmit FIFO while frozen
    wr(0, 8'h00);
    rd_chk(31, 8'h02, "R6 one entry");
    for (int i = 1; i < 16; i++) wr(0, 8'(i));
    rd_chk(31, 8'h00, "R6 full");
    wr(0, 8'h99);
    loop_en = 1'b1;
    set_div(16'd1);
    repeat (2700) @(negedge clk);
    rd_chk(31, 8'h06, "R6 drained");
    for (int i = 0; i < 16; i++) rd_chk(0, 8'(i), "R7 R8 order and drop");
    rd_chk(5, 8'h60, "R8 ready clears when empty");
    loop_en = 1'b0;

    // R4 / R5: frame shape at divisor 3
    set_div(16'd3);
    fork
      capture(48, cap, stp);
      begin
        wr(0, 8'hA5);
        repeat (6) @(negedge clk);
        rd_chk(5, 8'h20, "R5 serializer busy");
      end
    join
    check(cap, 8'hA5, "R4 data bits");
    check({7'b0, stp}, 8'h01, "R4 stop bit");
    repeat (40) @(negedge clk);
    rd_chk(5, 8'h60, "R5 line drained");

    // R9: overrun
    set_div(16'd1);
    for (int i = 0; i < 17; i++) send_frame(8'h40 + 8'(i), 1'b1, 16);
    repeat (20) @(negedge clk);
    rd_chk(5, 8'h63, "R9 overrun set");
    rd_chk(5, 8'h61, "R9 overrun cleared by read");
    for (int i = 0; i < 16; i++) rd_chk(0, 8'h40 + 8'(i), "R9 older bytes kept");

    // R10: low stop bit
    send_frame(8'h81, 1'b0, 16);
    repeat (40) @(negedge clk);
    rd_chk(5, 8'h69, "R10 framing flag");
    rd_chk(5, 8'h61, "R10 flag cleared by read");
    rd_chk(0, 8'h81, "R10 byte stored");
    rd_chk(5, 8'h60, "R10 no false restart");

    // R11: short glitch
    rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    rd_chk(5, 8'h60, "R11 glitch rejected");

    // R12: receive flush
    send_frame(8'h77, 1'b1, 16);
    repeat (20) @(negedge clk);
    rd_chk(5, 8'h61, "R12 byte waiting");
    wr(2, 8'h02);
    rd_chk(5, 8'h60, "R12 receive flush");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule